// File: doc/BRIEF.md
# Phased-Frame Serial Receiver

This block takes in framed serial data. An outside transmitter drives a bit clock, a frame-sync line and a data line. The block runs on its own system clock. It passes all three serial inputs through synchronizer flops and finds the sampling edge of the bit clock from the synchronized copy. For this to work, the bit clock must be at least four times slower than the system clock.

A frame has one phase or two. Each phase sets its own element count (1 to 128) and element width (8 to 32 bits). Every transfer begins with its own frame-sync pulse. The first data bit can land on the frame-sync bit slot, or zero to two slots after it. Between frames the line may stay idle for any length of time.

Each completed element is placed on a parallel output, right-justified. The output carries a one-cycle valid strobe, the phase number and the element index within that phase. The output register is overwritten by the next element. The block does not generate the bit clock or frame sync, and it adds no further buffering.

Top module: `frx_rx_top`

## Requirements
- R1: With `cfg_dual_phase` = 0 a frame carries only phase 0, and every element reports `elem_phase` = 0. With `cfg_dual_phase` = 1, all phase-0 elements come first, followed by the phase-1 elements, which report `elem_phase` = 1.
- R2: A length field of N (0 to 127) gives N+1 elements in that phase. `elem_index` counts 0 to N within each phase and restarts at 0 in phase 1.
- R3: Width codes map to element widths as follows: 0 = 8 bits, 1 = 12, 2 = 16, 3 = 20, 4 = 24, and 5, 6 or 7 = 32. Bits arrive MSB first. `elem_data` holds the element in its low bits, and all bits above the element width are zero.
- R4: When `cfg_dual_phase` = 0, the `cfg_len_b` and `cfg_wcode_b` settings have no effect on the number or content of the elements received.
- R5: `cfg_delay` sets where the first data bit falls, counted in sampling edges from the edge that first sees frame sync active: 0 = the same edge, 1 = the next edge, 2 = two edges later. Code 3 behaves like code 2.
- R6: `cfg_sample_rise` = 0 samples data and frame sync on falling edges of the bit clock. `cfg_sample_rise` = 1 samples them on rising edges.
- R7: `cfg_fsync_low` = 0 treats a high frame-sync level as active. `cfg_fsync_low` = 1 treats a low level as active.
- R8: A frame starts only when a sampling edge sees frame sync active after an edge that saw it inactive. Frame sync that goes active during a frame is ignored. After the last element, no further element is produced until a new frame sync arrives.
- R9: `elem_valid` is high for exactly one system-clock cycle per element. After reset, `elem_valid`, `elem_data`, `elem_phase` and `elem_index` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Incoming bit clock (asynchronous) |
| ser_fsync | input | 1 | Incoming frame sync (asynchronous) |
| ser_data | input | 1 | Incoming serial data (asynchronous) |
| cfg_dual_phase | input | 1 | 0 = one phase per frame, 1 = two phases |
| cfg_len_a | input | 7 | Phase 0 element count minus one |
| cfg_wcode_a | input | 3 | Phase 0 width code |
| cfg_len_b | input | 7 | Phase 1 element count minus one |
| cfg_wcode_b | input | 3 | Phase 1 width code |
| cfg_delay | input | 2 | Data delay after frame sync, in bit slots |
| cfg_sample_rise | input | 1 | 1 = sample on rising bit-clock edge |
| cfg_fsync_low | input | 1 | 1 = frame sync active low |
| elem_data | output | 32 | Received element, right-justified |
| elem_valid | output | 1 | One-cycle strobe for a new element |
| elem_phase | output | 1 | Phase of the element |
| elem_index | output | 7 | Element index within its phase |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- A frame of 128 one-byte elements, which catches an element counter that wraps or stops one short.
- A single-phase frame with garbage in the second-phase settings, which would add extra elements if those settings leaked into the single-phase case.
- All three data delays plus the reserved delay code. A wrong delay shifts every element by one bit, so the data checks fail.
- A frame-sync pulse placed mid-frame, which would restart the frame and corrupt or duplicate elements.
- Both bit-clock polarities and both frame-sync polarities, including random mixes. Getting either polarity wrong samples on the launch edge or never starts a frame.

// File: rtl/frx_pkg.sv
package frx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_DATA  = 2'd2
  } frx_state_e;

  localparam int WCODE_W = 3;

  // Element width in bits for a width code; unused codes give 32.
  function automatic logic [5:0] elem_bits(input logic [WCODE_W-1:0] code);
    case (code)
      3'd0:    elem_bits = 6'd8;
      3'd1:    elem_bits = 6'd12;
      3'd2:    elem_bits = 6'd16;
      3'd3:    elem_bits = 6'd20;
      3'd4:    elem_bits = 6'd24;
      default: elem_bits = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/frx_edge_sync.sv
module frx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_fsync,
  input  logic ser_data,
  input  logic cfg_sample_rise,
  input  logic cfg_fsync_low,
  output logic samp_edge,
  output logic fs_act,
  output logic bit_o
);

  logic [STAGES-1:0] clk_sr, fs_sr, dat_sr;
  logic              clk_prev;

  // All three lines pass through the same depth so they stay aligned.
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sr   <= '0;
      fs_sr    <= '0;
      dat_sr   <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sr   <= {clk_sr[STAGES-2:0], ser_clk};
      fs_sr    <= {fs_sr[STAGES-2:0], ser_fsync};
      dat_sr   <= {dat_sr[STAGES-2:0], ser_data};
      clk_prev <= clk_sr[STAGES-1];
    end
  end

  assign samp_edge = cfg_sample_rise ? ( clk_sr[STAGES-1] & ~clk_prev)
                                     : (~clk_sr[STAGES-1] &  clk_prev);
  assign fs_act    = fs_sr[STAGES-1] ^ cfg_fsync_low;
  assign bit_o     = dat_sr[STAGES-1];

  // R6: a sampling edge needs the synced clock to move since the last one
  p_edge_spaced_r6: assert property (@(posedge clk) disable iff (rst)
    samp_edge |=> !samp_edge);

endmodule

// File: rtl/frx_frame_ctl.sv
module frx_frame_ctl
  import frx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 samp_edge,
  input  logic                 fs_act,
  input  logic                 bit_i,
  input  logic                 cfg_dual_phase,
  input  logic [LEN_W-1:0]     cfg_len_a,
  input  logic [WCODE_W-1:0]   cfg_wcode_a,
  input  logic [LEN_W-1:0]     cfg_len_b,
  input  logic [WCODE_W-1:0]   cfg_wcode_b,
  input  logic [1:0]           cfg_delay,
  output logic [DATA_W-1:0]    out_data,
  output logic                 out_valid,
  output logic                 out_phase,
  output logic [LEN_W-1:0]     out_index
);

  localparam int BCW = $clog2(DATA_W);

  frx_state_e        state;
  logic              fs_prev;
  logic              cur_phase;
  logic [LEN_W-1:0]  cur_idx;
  logic [BCW-1:0]    bit_cnt;
  logic [DATA_W-1:0] shreg;

  logic              fs_start;
  logic [LEN_W-1:0]  cur_len;
  logic [5:0]        cur_bits;
  logic [BCW-1:0]    last_bit;
  logic [1:0]        eff_delay;

  always_comb begin
    fs_start  = fs_act & ~fs_prev;
    cur_len   = cur_phase ? cfg_len_b : cfg_len_a;
    cur_bits  = elem_bits(cur_phase ? cfg_wcode_b : cfg_wcode_a);
    last_bit  = BCW'(cur_bits - 6'd1);
    eff_delay = (cfg_delay == 2'd3) ? 2'd2 : cfg_delay;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      fs_prev   <= 1'b1;
      cur_phase <= 1'b0;
      cur_idx   <= '0;
      bit_cnt   <= '0;
      shreg     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_phase <= 1'b0;
      out_index <= '0;
    end else begin
      out_valid <= 1'b0;
      if (samp_edge) begin
        fs_prev <= fs_act;
        case (state)
          ST_IDLE: begin
            if (fs_start) begin
              cur_phase <= 1'b0;
              cur_idx   <= '0;
              bit_cnt   <= '0;
              shreg     <= '0;
              if (eff_delay == 2'd0) begin
                shreg   <= DATA_W'(bit_i);
                bit_cnt <= BCW'(1);
                state   <= ST_DATA;
              end else if (eff_delay == 2'd1) begin
                state <= ST_DATA;
              end else begin
                state <= ST_DELAY;
              end
            end
          end
          ST_DELAY: state <= ST_DATA;
          ST_DATA: begin
            if (bit_cnt == last_bit) begin
              out_data  <= {shreg[DATA_W-2:0], bit_i};
              out_valid <= 1'b1;
              out_phase <= cur_phase;
              out_index <= cur_idx;
              bit_cnt   <= '0;
              shreg     <= '0;
              if (cur_idx == cur_len) begin
                cur_idx <= '0;
                if (!cur_phase && cfg_dual_phase) cur_phase <= 1'b1;
                else                              state     <= ST_IDLE;
              end else begin
                cur_idx <= cur_idx + 1'b1;
              end
            end else begin
              shreg   <= {shreg[DATA_W-2:0], bit_i};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R9: strobe lasts one cycle
  p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R9: nothing is presented in the cycle after reset
  p_quiet_after_reset_r9: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  // R1: phase 1 only appears when two phases are configured
  p_phase_needs_dual_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!out_phase || cfg_dual_phase));

  // R2: reported index never exceeds the phase's length field
  p_index_bound_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_index <= (out_phase ? cfg_len_b : cfg_len_a)));

  // R3: 8-bit elements leave the upper bits clear
  p_upper_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_phase && cfg_wcode_a == 3'd0) |-> (out_data[DATA_W-1:8] == '0));

  // R8: an element is only produced while a frame is in progress
  p_no_idle_output_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !samp_edge) |=> !out_valid);

endmodule

// File: rtl/frx_rx_top.sv
module frx_rx_top
  import frx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_clk,
  input  logic                ser_fsync,
  input  logic                ser_data,
  input  logic                cfg_dual_phase,
  input  logic [LEN_W-1:0]    cfg_len_a,
  input  logic [2:0]          cfg_wcode_a,
  input  logic [LEN_W-1:0]    cfg_len_b,
  input  logic [2:0]          cfg_wcode_b,
  input  logic [1:0]          cfg_delay,
  input  logic                cfg_sample_rise,
  input  logic                cfg_fsync_low,
  output logic [DATA_W-1:0]   elem_data,
  output logic                elem_valid,
  output logic                elem_phase,
  output logic [LEN_W-1:0]    elem_index
);

  logic samp_edge, fs_act, rx_bit;

  frx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk             (clk),
    .rst             (rst),
    .ser_clk         (ser_clk),
    .ser_fsync       (ser_fsync),
    .ser_data        (ser_data),
    .cfg_sample_rise (cfg_sample_rise),
    .cfg_fsync_low   (cfg_fsync_low),
    .samp_edge       (samp_edge),
    .fs_act          (fs_act),
    .bit_o           (rx_bit)
  );

  frx_frame_ctl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctl (
    .clk            (clk),
    .rst            (rst),
    .samp_edge      (samp_edge),
    .fs_act         (fs_act),
    .bit_i          (rx_bit),
    .cfg_dual_phase (cfg_dual_phase),
    .cfg_len_a      (cfg_len_a),
    .cfg_wcode_a    (cfg_wcode_a),
    .cfg_len_b      (cfg_len_b),
    .cfg_wcode_b    (cfg_wcode_b),
    .cfg_delay      (cfg_delay),
    .out_data       (elem_data),
    .out_valid      (elem_valid),
    .out_phase      (elem_phase),
    .out_index      (elem_index)
  );

endmodule

// File: tb/tb_frx_rx_top.sv
module tb_frx_rx_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0, ser_fsync = 1'b0, ser_data = 1'b0;
  logic        cfg_dual_phase = 1'b0;
  logic [6:0]  cfg_len_a = '0, cfg_len_b = '0;
  logic [2:0]  cfg_wcode_a = '0, cfg_wcode_b = '0;
  logic [1:0]  cfg_delay = 2'd1;
  logic        cfg_sample_rise = 1'b0, cfg_fsync_low = 1'b0;
  logic [31:0] elem_data;
  logic        elem_valid, elem_phase;
  logic [6:0]  elem_index;

  always #4 clk = ~clk;

  frx_rx_top dut (.*);

  int checks = 0, fails = 0;
  int exp_n = 0, got_n = 0;
  logic [31:0] exp_d  [512];
  logic        exp_ph [512];
  logic [6:0]  exp_ix [512];
  logic        bitq   [8192];
  logic        prev_valid = 1'b0;
  bit          done = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bw(input logic [2:0] code);
    case (code)
      3'd0: return 8;   3'd1: return 12;  3'd2: return 16;
      3'd3: return 20;  3'd4: return 24;  default: return 32;
    endcase
  endfunction

  // Monitor: compare each strobe against the expected list
  always @(negedge clk) begin
    if (!rst) begin
      if (elem_valid) begin
        chk("R9", "valid longer than one cycle", {31'd0, prev_valid}, 32'd0);
        if (got_n < exp_n) begin
          chk("R3", "element data",  elem_data, exp_d[got_n]);
          chk("R1", "element phase", {31'd0, elem_phase}, {31'd0, exp_ph[got_n]});
          chk("R2", "element index", {25'd0, elem_index}, {25'd0, exp_ix[got_n]});
        end else begin
          chk("R8", "unexpected element", got_n + 1, exp_n);
        end
        got_n++;
      end
      prev_valid = elem_valid;
    end
  end

  // One bit slot: launch edge, half period, sampling edge, half period
  task automatic send_slot(input logic fs_on, input logic d);
    ser_clk   = ~cfg_sample_rise;
    ser_fsync = fs_on ^ cfg_fsync_low;
    ser_data  = d;
    repeat (4) @(negedge clk);
    ser_clk = cfg_sample_rise;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame(string req, logic dual, logic [6:0] la, logic [2:0] wa,
                           logic [6:0] lb, logic [2:0] wb, logic [1:0] dly,
                           logic rise, logic fslow, int extra_fs);
    int nb, d;
    cfg_dual_phase = dual; cfg_len_a = la; cfg_wcode_a = wa;
    cfg_len_b = lb; cfg_wcode_b = wb; cfg_delay = dly;
    cfg_sample_rise = rise; cfg_fsync_low = fslow;
    for (int i = 0; i < 2; i++) send_slot(1'b0, 1'b0);
    exp_n = 0; got_n = 0; nb = 0;
    for (int ph = 0; ph <= (dual ? 1 : 0); ph++) begin
      int n, w;
      logic [63:0] v;
      n = (ph == 1) ? int'(lb) : int'(la);
      w = bw((ph == 1) ? wb : wa);
      for (int e = 0; e <= n; e++) begin
        v = {32'd0, $urandom} & ((64'd1 << w) - 64'd1);
        exp_d[exp_n]  = v[31:0];
        exp_ph[exp_n] = ph[0];
        exp_ix[exp_n] = e[6:0];
        exp_n++;
        for (int b = w - 1; b >= 0; b--) begin
          bitq[nb] = v[b];
          nb++;
        end
      end
    end
    d = (dly == 2'd3) ? 2 : int'(dly);
    for (int s = 0; s < d + nb + 3; s++) begin
      logic dat;
      dat = (s >= d && s < d + nb) ? bitq[s - d] : logic'($urandom % 2);
      send_slot((s == 0) || (s == extra_fs), dat);
    end
    repeat (12) @(negedge clk);
    chk(req, "element count", got_n, exp_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9", "valid after reset", {31'd0, elem_valid}, 32'd0);
    chk("R9", "data after reset",  elem_data, 32'd0);
    chk("R9", "index after reset", {25'd0, elem_index}, 32'd0);

    // R1/R5: single phase, one byte, one-bit delay, default polarities
    run_frame("R1", 1'b0, 7'd0, 3'd0, 7'd0, 3'd0, 2'd1, 1'b0, 1'b0, -1);
    // R1/R5: dual phase, zero delay
    run_frame("R1", 1'b1, 7'd2, 3'd2, 7'd1, 3'd5, 2'd0, 1'b0, 1'b0, -1);
    // R5/R6: two-bit delay, rising-edge sampling
    run_frame("R6", 1'b0, 7'd3, 3'd1, 7'd0, 3'd0, 2'd2, 1'b1, 1'b0, -1);
    // R5: reserved delay code acts as two
    run_frame("R5", 1'b1, 7'd1, 3'd3, 7'd1, 3'd4, 2'd3, 1'b0, 1'b0, -1);
    // R7: active-low frame sync, both edge senses
    run_frame("R7", 1'b0, 7'd2, 3'd0, 7'd0, 3'd0, 2'd1, 1'b0, 1'b1, -1);
    run_frame("R7", 1'b1, 7'd0, 3'd2, 7'd2, 3'd1, 2'd0, 1'b1, 1'b1, -1);
    // R4: second-phase settings ignored in a single-phase frame
    run_frame("R4", 1'b0, 7'd2, 3'd0, 7'd127, 3'd5, 2'd1, 1'b0, 1'b0, -1);
    // R8: frame sync pulses mid-frame are ignored
    run_frame("R8", 1'b0, 7'd3, 3'd0, 7'd0, 3'd0, 2'd1, 1'b0, 1'b0, 5);
    run_frame("R8", 1'b1, 7'd1, 3'd2, 7'd1, 3'd0, 2'd0, 1'b1, 1'b1, 20);
    // R8: no elements appear without a new frame sync
    got_n = 0; exp_n = 0;
    for (int i = 0; i < 40; i++) send_slot(1'b0, logic'($urandom % 2));
    chk("R8", "elements without frame sync", got_n, 0);
    // R2: longest phase, 128 byte elements
    run_frame("R2", 1'b0, 7'd127, 3'd0, 7'd0, 3'd0, 2'd1, 1'b0, 1'b0, -1);
    // R3: every width code
    for (int c = 0; c < 8; c++)
      run_frame("R3", 1'b0, 7'd1, c[2:0], 7'd0, 3'd0, 2'd1, 1'b0, 1'b0, -1);
    // Random mixes
    for (int k = 0; k < 14; k++) begin
      logic [1:0] dl;
      dl = 2'($urandom % 4);
      run_frame("R1", logic'($urandom % 2), 7'($urandom % 4), 3'($urandom % 8),
                7'($urandom % 4), 3'($urandom % 8), dl,
                logic'($urandom % 2), logic'($urandom % 2),
                (k % 3 == 0) ? 4 + int'($urandom % 8) : -1);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule